// File: doc/BRIEF.md
# Nanosecond Time Counter with Fractional Increment

A free-running time base that keeps a 64-bit count of nanoseconds. On every enabled clock tick it adds a 40-bit fixed-point increment (8 integer bits, 32 fraction bits) into a 96-bit accumulator. The accumulator is the 64-bit nanosecond count with a 32-bit fraction below it, so carries from the fraction reach the count without loss. The 64-bit count is wide enough that wrap-around never needs handling.

Software reaches the block through a 32-bit register port of four words. Reading the low time word captures the upper half into a snapshot, so a later high-word read gives a coherent 64-bit value. Writing the low time word or the low increment word only stages the data. The matching high-word write commits the whole 64-bit time or 40-bit increment in one cycle. A link-rate code scales the programmed increment, because the tick period depends on the link speed. A run input gates all advancement.

Top module: `ns_time_counter`

## Requirements
- R1: After synchronous reset the time is 0, and the increment is 0x01_99999999 (1.6 ns). It reads back as 0x99999999 at address 2 and 0x00000001 at address 3. The address map is: 0 time low, 1 time high, 2 increment low, 3 increment high.
- R2: Each tick with `run_en` high adds the effective increment to {time, fraction}. After N ticks from a commit, the time equals the committed value plus floor(N × effective increment / 2^32).
- R3: The effective increment is the committed increment times a factor set by `link_code`: 0 gives ×1, 1 gives ×2, 2 gives ×2, 3 gives ×20, and 5 to 7 give ×1.
- R4: `link_code` 4 gives a factor of 0, so the time does not advance.
- R5: While `run_en` is low the time holds its value, and register reads and writes still work.
- R6: A read of address 0 returns the live low word and captures the live upper word. A read of address 1 returns that captured upper word, even if the time has since advanced.
- R7: A write to address 0 only stages the data. The time is unchanged.
- R8: A write to address 1 sets the time to {wdata, staged low word} at that edge and clears the fraction.
- R9: When a time commit and an enabled tick fall in the same cycle, the commit wins.
- R10: A write to address 2 only stages the data. A write to address 3 commits {wdata[7:0], staged low} as the new increment. Addresses 2 and 3 read back the committed increment, with the high word zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Allows the time to advance |
| link_code | input | 3 | Link-rate code that selects the increment factor |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (address 0 captures the snapshot) |
| addr | input | 2 | Register word address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from `addr` |

## Verification
A table of cases runs the counter from different start times, for different tick counts, under every link factor. These cases tell a wrong factor from a wrong truncation of the fraction. One case crosses the 32-bit boundary to expose a lost carry into the high word. Directed cases use a staged-only write to separate staging from committing, and advance the clock between the low and high reads to separate snapshot from live reads. A commit issued during a tick, with a known fraction left over, shows whether the commit wins and whether the fraction is cleared.

// File: rtl/ntc_pkg.sv
package ntc_pkg;
    localparam int TIME_W    = 64;
    localparam int FRAC_W    = 32;
    localparam int INC_INT_W = 8;
    localparam int INC_W     = INC_INT_W + FRAC_W;
    localparam int MULT_W    = 5;
    localparam int EFF_W     = INC_W + MULT_W;
    localparam int ACC_W     = TIME_W + FRAC_W;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 2;
    localparam int CODE_W    = 3;

    localparam logic [INC_W-1:0] BASE_INC = 40'h01_9999_9999;

    typedef enum logic [CODE_W-1:0] {
        LINK_FAST = 3'd0,
        LINK_10G  = 3'd1,
        LINK_5G   = 3'd2,
        LINK_1G   = 3'd3,
        LINK_100M = 3'd4
    } link_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_TIME_LO = 2'd0,
        REG_TIME_HI = 2'd1,
        REG_INC_LO  = 2'd2,
        REG_INC_HI  = 2'd3
    } reg_e;

    typedef struct packed {
        logic [TIME_W-1:0] ns;
        logic [FRAC_W-1:0] frac;
    } acc_t;

    function automatic logic [MULT_W-1:0] link_factor(input logic [CODE_W-1:0] code);
        case (code)
            LINK_10G,
            LINK_5G:   return MULT_W'(2);
            LINK_1G:   return MULT_W'(20);
            LINK_100M: return MULT_W'(0);
            default:   return MULT_W'(1);
        endcase
    endfunction
endpackage

// File: rtl/ntc_rate.sv
module ntc_rate
    import ntc_pkg::*;
(
    input  logic [INC_W-1:0]  inc_q,
    input  logic [CODE_W-1:0] link_code,
    output logic [EFF_W-1:0]  eff_inc
);
    logic [MULT_W-1:0] factor;

    // R3 / R4: scale the programmed increment by the link factor
    assign factor  = link_factor(link_code);
    assign eff_inc = EFF_W'(inc_q) * EFF_W'(factor);
endmodule

// File: rtl/ntc_regif.sv
module ntc_regif
    import ntc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [TIME_W-1:0] live_ns,
    output logic [WORD_W-1:0] rdata,
    output logic              time_commit,
    output logic [TIME_W-1:0] commit_val,
    output logic [INC_W-1:0]  inc_q
);
    reg_e              sel;
    logic [WORD_W-1:0] stage_time_lo;
    logic [WORD_W-1:0] stage_inc_lo;
    logic [WORD_W-1:0] snap_hi;

    assign sel         = reg_e'(addr);
    assign time_commit = wr_en && (sel == REG_TIME_HI);
    assign commit_val  = {wdata, stage_time_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_time_lo <= '0;
            stage_inc_lo  <= '0;
            snap_hi       <= '0;
            inc_q         <= BASE_INC;
        end else begin
            if (wr_en) begin
                case (sel)
                    REG_TIME_LO: stage_time_lo <= wdata;
                    REG_INC_LO:  stage_inc_lo  <= wdata;
                    REG_INC_HI:  inc_q <= {wdata[INC_INT_W-1:0], stage_inc_lo};
                    default: ;
                endcase
            end
            if (rd_en && (sel == REG_TIME_LO))
                snap_hi <= live_ns[TIME_W-1:WORD_W];
        end
    end

    always_comb begin
        case (sel)
            REG_TIME_LO: rdata = live_ns[WORD_W-1:0];
            REG_TIME_HI: rdata = snap_hi;
            REG_INC_LO:  rdata = inc_q[WORD_W-1:0];
            default:     rdata = WORD_W'(inc_q[INC_W-1:FRAC_W]);
        endcase
    end

    assert_snapshot_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == REG_TIME_LO) |=> (snap_hi == $past(live_ns[TIME_W-1:WORD_W])));

    assert_inc_staged_R10: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == REG_INC_HI) |=> $stable(inc_q));
endmodule

// File: rtl/ntc_accum.sv
module ntc_accum
    import ntc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic [EFF_W-1:0]  eff_inc,
    input  logic              commit,
    input  logic [TIME_W-1:0] commit_val,
    output logic [TIME_W-1:0] ns
);
    acc_t acc_q;
    acc_t acc_sum;

    assign acc_sum = acc_t'(acc_q + ACC_W'(eff_inc));
    assign ns      = acc_q.ns;

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (commit)                 // R9: commit wins over tick
            acc_q <= '{ns: commit_val, frac: '0};
        else if (run_en)
            acc_q <= acc_sum;
    end

    assert_hold_off_R5: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !commit) |=> $stable(acc_q));

    assert_zero_inc_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (eff_inc == '0 && !commit) |=> $stable(acc_q));

    assert_commit_load_R8: assert property (@(posedge clk) disable iff (rst)
        commit |=> (acc_q.ns == $past(commit_val) && acc_q.frac == '0));
endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter
    import ntc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic [CODE_W-1:0] link_code,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [TIME_W-1:0] live_ns;
    logic [TIME_W-1:0] commit_val;
    logic              time_commit;
    logic [INC_W-1:0]  inc_q;
    logic [EFF_W-1:0]  eff_inc;

    ntc_regif u_regif (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .live_ns(live_ns), .rdata(rdata),
        .time_commit(time_commit), .commit_val(commit_val), .inc_q(inc_q)
    );

    ntc_rate u_rate (
        .inc_q(inc_q), .link_code(link_code), .eff_inc(eff_inc)
    );

    ntc_accum u_accum (
        .clk(clk), .rst(rst), .run_en(run_en), .eff_inc(eff_inc),
        .commit(time_commit), .commit_val(commit_val), .ns(live_ns)
    );
endmodule

// File: tb/sim_ns_time_counter.sv
module sim_ns_time_counter;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] BASE = 64'h01_9999_9999;

    typedef struct packed {
        logic [2:0]  code;
        logic [31:0] n;
        logic [63:0] start;
        logic [31:0] mult;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 32'd10,  64'd0,                   32'd1},
        '{3'd1, 32'd25,  64'd1000,                32'd2},
        '{3'd2, 32'd7,   64'h1234_5678_0000_0000, 32'd2},
        '{3'd3, 32'd5,   64'h0000_0000_FFFF_FFF0, 32'd20},
        '{3'd5, 32'd33,  64'd77,                  32'd1},
        '{3'd7, 32'd3,   64'd5,                   32'd1},
        '{3'd3, 32'd100, 64'hFFFF_0000_0000_0000, 32'd20}
    };

    logic        clk = 0;
    logic        rst = 1;
    logic        run_en = 0;
    logic [2:0]  link_code = 0;
    logic        wr_en = 0;
    logic        rd_en = 0;
    logic [1:0]  addr = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;

    ns_time_counter u0 (.clk(clk), .rst(rst), .run_en(run_en), .link_code(link_code),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        rd_en = 1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic read_time(output logic [63:0] t);
        logic [31:0] lo, hi;
        rd_reg(2'd0, lo);
        rd_reg(2'd1, hi);
        t = {hi, lo};
    endtask

    task automatic set_time(input logic [63:0] t);
        wr_reg(2'd0, t[31:0]);
        wr_reg(2'd1, t[63:32]);
    endtask

    task automatic run_ticks(input int n);
        run_en = 1;
        repeat (n) @(negedge clk);
        run_en = 0;
    endtask

    function automatic logic [63:0] expect_after(input logic [63:0] start, input logic [63:0] inc,
                                                 input logic [63:0] mult, input logic [63:0] n);
        return start + ((n * inc * mult) >> 32);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] t;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        read_time(t);
        check("R1 time", t, 64'd0);
        rd_reg(2'd2, w); check("R1 inc lo", {32'd0, w}, 64'h9999_9999);
        rd_reg(2'd3, w); check("R1 inc hi", {32'd0, w}, 64'h1);

        // R2 / R3: table of link factors and tick counts
        for (int i = 0; i < NV; i++) begin
            link_code = VECS[i].code;
            set_time(VECS[i].start);
            run_ticks(int'(VECS[i].n));
            read_time(t);
            check($sformatf("R2 R3 vector %0d", i), t,
                  expect_after(VECS[i].start, BASE, 64'(VECS[i].mult), 64'(VECS[i].n)));
        end

        // R4: 100M code stops the clock
        link_code = 3'd4;
        set_time(64'd42);
        run_ticks(50);
        read_time(t);
        check("R4 stopped", t, 64'd42);

        // R5: run_en low holds; R7: low write alone has no effect
        link_code = 3'd0;
        set_time(64'd9);
        repeat (20) @(negedge clk);
        read_time(t);
        check("R5 hold", t, 64'd9);
        wr_reg(2'd0, 32'd123);
        read_time(t);
        check("R7 staged low", t, 64'd9);

        // R6: snapshot of the high word
        link_code = 3'd3;
        set_time(64'h0000_0000_FFFF_FF00);
        rd_reg(2'd0, w);
        check("R6 live low", {32'd0, w}, 64'hFFFF_FF00);
        run_ticks(20);
        rd_reg(2'd1, w);
        check("R6 captured high", {32'd0, w}, 64'd0);
        read_time(t);
        check("R6 fresh read", t, expect_after(64'h0000_0000_FFFF_FF00, BASE, 64'd20, 64'd20));

        // R8 / R9: commit during a tick wins and clears the fraction
        link_code = 3'd0;
        set_time(64'd1000);
        run_ticks(3);
        run_en = 1;
        wr_reg(2'd0, 32'd5000);
        wr_reg(2'd1, 32'd0);
        run_en = 0;
        read_time(t);
        check("R9 commit wins", t, 64'd5000);
        run_ticks(5);
        read_time(t);
        check("R8 fraction cleared", t, 64'd5007);

        // R10: increment staging and commit
        wr_reg(2'd2, 32'd0);
        rd_reg(2'd2, w);
        check("R10 inc lo staged", {32'd0, w}, 64'h9999_9999);
        set_time(64'd0);
        run_ticks(7);
        read_time(t);
        check("R10 old inc still used", t, expect_after(64'd0, BASE, 64'd1, 64'd7));
        wr_reg(2'd3, 32'h0000_0005);
        rd_reg(2'd2, w); check("R10 inc lo", {32'd0, w}, 64'd0);
        rd_reg(2'd3, w); check("R10 inc hi", {32'd0, w}, 64'd5);
        set_time(64'd0);
        run_ticks(7);
        read_time(t);
        check("R10 new inc", t, 64'd35);
        link_code = 3'd3;
        set_time(64'd0);
        run_ticks(2);
        read_time(t);
        check("R10 R3 new inc x20", t, 64'd200);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule